// File: doc/BRIEF.md
# Three-Level Clamped Leg Gate Sequencer

This block drives the four series switches of one diode-clamped leg that can output three levels: positive, zero (clamped to the midpoint) and negative. A controller asks for a level on a 2-bit request input. The block turns that request into four gate lines. Each change of level follows the same order: the switch that must turn off drops first, a programmable dead-time gap follows, and only then does the switch that must turn on rise.

A request that would jump straight between the positive and negative levels is never carried out directly. The leg first steps to the zero level, dwells there for at least one dead-time interval plus one clock, and then continues to the requested level. A one-clock flag reports that the request was rerouted. After every applied step there is a dwell of the same length before a new request is taken. Reset, or dropping the enable, parks the leg in the zero pattern at once with no gap. A later enable starts from there.

Top module: `clamp_leg_gate`

## Requirements
- R1: Level codes are 2'b00 zero, 2'b01 positive and 2'b10 negative, on both `reqLvl` and `lvlOut`. Gate bit i drives switch i+1. In the steady state the gates read 4'b0011 for positive, 4'b0110 for zero and 4'b1100 for negative.
- R2: An adjacent step sampled at clock edge k works as follows.
  - At edge k the gates become the AND of the old and new patterns, so the outgoing switch is low and the incoming switch is not yet on.
  - This gap holds for deadCnt+1 cycles.
  - At edge k+deadCnt+1 the new pattern and the new `lvlOut` appear together.
- R3: A request from positive to negative, or the reverse, steps to zero first, using the R2 timing.
  - The zero pattern then holds for deadCnt+2 cycles.
  - A second gap of deadCnt+1 cycles follows, then the requested level.
  - `lvlOut` never moves directly between positive and negative.
- R4: `rerouteOut` is high for exactly one cycle, the cycle after the edge that accepts a rerouted request. It is low in every other case.
- R5: The target level is fixed when a step starts. Changes of `reqLvl` during the gap do not alter it. After each applied level, a dwell of deadCnt+1 cycles passes before a new request is evaluated.
- R6: An asynchronous active-low reset sets the gates to 4'b0110, sets `lvlOut` to zero and clears `rerouteOut`, without waiting for a clock.
- R7: When `enable` is low at an edge, that edge applies the zero pattern and zero level with no gap, and abandons any step in progress. Once `enable` returns high, sequencing starts from the zero level.
- R8: A request of 2'b11, or a request equal to the current level, leaves the gates and `lvlOut` unchanged.
- R9: Switches 1 and 3 are never on together, and switches 2 and 4 are never on together, in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low parks the leg at zero |
| reqLvl | input | 2 | Requested level code |
| deadCnt | input | DT_W | Dead-time count; the gap is deadCnt+1 cycles |
| gateOut | output | 4 | Gate lines, bit i for switch i+1 |
| lvlOut | output | 2 | Level currently applied |
| rerouteOut | output | 1 | One-cycle pulse when a request is rerouted through zero |

## Verification
The hardest situation to reach from the ports is a step that is disturbed partway through. Two cases matter: the request changes inside the gap, and the enable drops while a rerouted step is still in its first gap. The stimulus handles both by first parking the leg at a known level, then issuing a request and changing `reqLvl` or `enable` a fixed number of cycles later. Those cycles are counted from the known edge that accepted the request. The full set of start levels, request codes and several dead-time counts is swept, and every cycle of each transition is compared against timing derived from deadCnt.

// File: rtl/clamp_leg_pkg.sv
package clamp_leg_pkg;

  localparam int GATE_N = 4;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b10,
    LVL_NONE = 2'b11
  } lvl_e;

  // Steady gate pattern of each level; bit i drives switch i+1.
  function automatic logic [GATE_N-1:0] lvlGates(lvl_e lvl);
    case (lvl)
      LVL_POS: lvlGates = 4'b0011;
      LVL_NEG: lvlGates = 4'b1100;
      default: lvlGates = 4'b0110;
    endcase
  endfunction

  // Strobes from sequencing control to the gate datapath.
  typedef struct packed {
    logic forceZero;
    logic beginGap;
    logic applyTgt;
    logic decCnt;
    lvl_e nextLvl;
  } strobe_t;

endpackage

// File: rtl/leg_gate_path.sv
module leg_gate_path
  import clamp_leg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DT_W-1:0]   deadCnt,
  output logic [GATE_N-1:0] gateQ,
  output lvl_e              curLvl,
  output logic              cntZero
);

  logic [DT_W-1:0] cnt;
  lvl_e            tgtLvl;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      gateQ  <= lvlGates(LVL_ZERO);
      curLvl <= LVL_ZERO;
      tgtLvl <= LVL_ZERO;
    end else if (strb.forceZero) begin
      cnt    <= '0;
      gateQ  <= lvlGates(LVL_ZERO);
      curLvl <= LVL_ZERO;
      tgtLvl <= LVL_ZERO;
    end else if (strb.beginGap) begin
      // outgoing switch drops now, incoming one waits for the gap
      cnt    <= deadCnt;
      gateQ  <= lvlGates(curLvl) & lvlGates(strb.nextLvl);
      tgtLvl <= strb.nextLvl;
    end else if (strb.applyTgt) begin
      cnt    <= deadCnt;
      gateQ  <= lvlGates(tgtLvl);
      curLvl <= tgtLvl;
    end else if (strb.decCnt) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/leg_seq_ctrl.sv
module leg_seq_ctrl
  import clamp_leg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  lvl_e    reqLvl,
  input  lvl_e    curLvl,
  input  logic    cntZero,
  output strobe_t strb,
  output logic    rerouteQ
);

  typedef enum logic [1:0] {PH_STEADY, PH_GAP, PH_DWELL} phase_e;

  phase_e phase, phaseNext;
  logic   stepReq, crossReq;

  assign crossReq = (reqLvl == LVL_POS && curLvl == LVL_NEG) ||
                    (reqLvl == LVL_NEG && curLvl == LVL_POS);
  assign stepReq  = (reqLvl != LVL_NONE) && (reqLvl != curLvl);

  always_comb begin
    strb.forceZero = 1'b0;
    strb.beginGap  = 1'b0;
    strb.applyTgt  = 1'b0;
    strb.decCnt    = 1'b0;
    strb.nextLvl   = LVL_ZERO;
    phaseNext      = phase;
    if (!enable) begin
      strb.forceZero = 1'b1;
      phaseNext      = PH_STEADY;
    end else begin
      case (phase)
        PH_STEADY: if (stepReq) begin
          strb.beginGap = 1'b1;
          strb.nextLvl  = crossReq ? LVL_ZERO : reqLvl;
          phaseNext     = PH_GAP;
        end
        PH_GAP: if (cntZero) begin
          strb.applyTgt = 1'b1;
          phaseNext     = PH_DWELL;
        end else begin
          strb.decCnt = 1'b1;
        end
        PH_DWELL: if (cntZero) begin
          phaseNext = PH_STEADY;
        end else begin
          strb.decCnt = 1'b1;
        end
        default: phaseNext = PH_STEADY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_STEADY;
      rerouteQ <= 1'b0;
    end else begin
      phase    <= phaseNext;
      rerouteQ <= enable && (phase == PH_STEADY) && stepReq && crossReq;
    end
  end

endmodule

// File: rtl/clamp_leg_gate.sv
module clamp_leg_gate
  import clamp_leg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic [1:0]      reqLvl,
  input  logic [DT_W-1:0] deadCnt,
  output logic [3:0]      gateOut,
  output logic [1:0]      lvlOut,
  output logic            rerouteOut
);

  strobe_t strb;
  lvl_e    curLvl;
  logic    cntZero;

  leg_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .reqLvl   (lvl_e'(reqLvl)),
    .curLvl   (curLvl),
    .cntZero  (cntZero),
    .strb     (strb),
    .rerouteQ (rerouteOut)
  );

  leg_gate_path #(.DT_W(DT_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .deadCnt (deadCnt),
    .gateQ   (gateOut),
    .curLvl  (curLvl),
    .cntZero (cntZero)
  );

  assign lvlOut = curLvl;

endmodule

// File: rtl/clamp_leg_gate_chk.sv
module clamp_leg_gate_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [3:0] gateOut,
  input logic [1:0] lvlOut,
  input logic       rerouteOut
);

  // R9
  no_shoot13_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(gateOut[0] && gateOut[2]));

  // R9
  no_shoot24_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(gateOut[1] && gateOut[3]));

  // R1
  gate_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(gateOut) == 1) || ($countones(gateOut) == 2));

  // R2
  off_before_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && ((gateOut & ~$past(gateOut)) != 4'b0000))
      |-> (($past(gateOut) & ~gateOut) == 4'b0000));

  // R3
  no_pos_to_neg_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lvlOut) == 2'b01) |-> (lvlOut != 2'b10));

  // R3
  no_neg_to_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lvlOut) == 2'b10) |-> (lvlOut != 2'b01));

  // R4
  flag_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rerouteOut |=> !rerouteOut);

  // R7
  park_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> (gateOut == 4'b0110 && lvlOut == 2'b00));

  // R8
  legal_lvl_chk: assert property (@(posedge clk) disable iff (!rstN)
    lvlOut != 2'b11);

endmodule

bind clamp_leg_gate clamp_leg_gate_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .gateOut    (gateOut),
  .lvlOut     (lvlOut),
  .rerouteOut (rerouteOut)
);

// File: tb/test_clamp_leg_gate.sv
module test_clamp_leg_gate;

  localparam int DT_W = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            enable = 1'b0;
  logic [1:0]      reqLvl = 2'b00;
  logic [DT_W-1:0] deadCnt = '0;
  logic [3:0]      gateOut;
  logic [1:0]      lvlOut;
  logic            rerouteOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  clamp_leg_gate #(.DT_W(DT_W)) i_clamp_leg_gate (
    .clk(clk), .rstN(rstN), .enable(enable), .reqLvl(reqLvl),
    .deadCnt(deadCnt), .gateOut(gateOut), .lvlOut(lvlOut),
    .rerouteOut(rerouteOut)
  );

  function automatic logic [3:0] pat(logic [1:0] l);
    case (l)
      2'b01:   return 4'b0011;
      2'b10:   return 4'b1100;
      default: return 4'b0110;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R9 switch pair overlap", int'((gateOut[0] & gateOut[2]) | (gateOut[1] & gateOut[3])), 0);
  endtask

  task automatic settleAt(input logic [1:0] s, input int d);
    deadCnt = DT_W'(d);
    enable  = 1'b0;
    reqLvl  = 2'b00;
    tick();
    enable = 1'b1;
    tick();
    if (s != 2'b00) begin
      reqLvl = s;
      repeat (2 * d + 4) tick();
    end
    chk("R2 settle level", int'(lvlOut), int'(s));
    chk("R1 settle gates", int'(gateOut), int'(pat(s)));
  endtask

  task automatic runCase(input logic [1:0] s, input logic [1:0] r, input int d);
    int kind;
    int lim;
    logic [3:0] eg;
    logic [1:0] el;
    logic ef;
    string tag;
    settleAt(s, d);
    if (r == 2'b11 || r == s) begin
      kind = 0; lim = 2 * d + 4; tag = "R8 ignored request";
    end else if (s != 2'b00 && r != 2'b00) begin
      kind = 2; lim = 3 * d + 5; tag = "R3 rerouted step";
    end else begin
      kind = 1; lim = 2 * d + 3; tag = "R2 adjacent step";
    end
    reqLvl = r;
    for (int j = 0; j <= lim; j++) begin
      tick();
      ef = 1'b0;
      if (kind == 0) begin
        eg = pat(s); el = s;
      end else if (kind == 1) begin
        if (j <= d) begin eg = pat(s) & pat(r); el = s; end
        else begin eg = pat(r); el = r; end
      end else begin
        ef = (j == 0);
        if (j <= d) begin eg = pat(s) & pat(2'b00); el = s; end
        else if (j <= 2 * d + 2) begin eg = pat(2'b00); el = 2'b00; end
        else if (j <= 3 * d + 3) begin eg = pat(2'b00) & pat(r); el = 2'b00; end
        else begin eg = pat(r); el = r; end
      end
      chk({tag, " gates"}, int'(gateOut), int'(eg));
      chk({tag, " level"}, int'(lvlOut), int'(el));
      chk("R4 reroute flag", int'(rerouteOut), int'(ef));
    end
  endtask

  initial begin
    int dts[4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    // R6 state while held in reset
    chk("R6 reset gates", int'(gateOut), 6);
    chk("R6 reset level", int'(lvlOut), 0);
    chk("R6 reset flag", int'(rerouteOut), 0);
    rstN = 1'b1;
    tick();

    // R1 R2 R3 R4 R8 sweep
    for (int di = 0; di < 4; di++)
      for (int s = 0; s < 3; s++)
        for (int r = 0; r < 4; r++)
          runCase(2'(s), 2'(r), dts[di]);

    // R5 target fixed at step start
    settleAt(2'b00, 3);
    reqLvl = 2'b01;
    tick();
    chk("R5 gap start", int'(gateOut), 4'b0010);
    reqLvl = 2'b10;
    for (int j = 1; j <= 3; j++) begin
      tick();
      chk("R5 gap held", int'(gateOut), 4'b0010);
    end
    tick();
    chk("R5 latched target level", int'(lvlOut), 1);
    chk("R5 latched target gates", int'(gateOut), 4'b0011);

    // R7 disable during a rerouted gap
    settleAt(2'b01, 4);
    reqLvl = 2'b10;
    tick();
    chk("R7 pre gap", int'(gateOut), 4'b0010);
    tick();
    enable = 1'b0;
    tick();
    chk("R7 parked gates", int'(gateOut), 4'b0110);
    chk("R7 parked level", int'(lvlOut), 0);
    reqLvl = 2'b01;
    enable = 1'b1;
    tick();
    chk("R7 restart from zero", int'(gateOut), 4'b0010);
    repeat (5) tick();
    chk("R7 restart arrival", int'(lvlOut), 1);

    // R6 asynchronous reset mid operation
    settleAt(2'b10, 2);
    #1 rstN = 1'b0;
    #1;
    chk("R6 async gates", int'(gateOut), 6);
    chk("R6 async level", int'(lvlOut), 0);
    chk("R6 async flag", int'(rerouteOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    tick();

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule